// File: doc/BRIEF.md
# Temperature-Driven Fan Speed Controller

This block turns a digital chassis temperature reading into a pulse-width-modulated fan drive. Each temperature sample arrives in whole degrees Celsius with a one-cycle valid strobe. The block maps the sample onto a fan curve with three regions. The duty is flat at a floor value at or below a lower set point. It rises linearly between the lower and the upper set point. It is pinned at full drive at or above the upper set point. The curve turns the sample into a duty level, and a free-running counter turns that level into a PWM waveform.

A new duty level never takes effect in the middle of a PWM period. It is held as a pending value and moved into the active register only at the end of a period, so every period is whole. Until the first sample has taken effect after reset, the fan is driven at full duty as a safe default. The active duty is also brought out on a port so that it can be observed.

With default parameters the counter is 8 bits wide, so a period is 256 clocks. The duty scale runs from 0 to 256, and 256 means always on. The lower set point is 30 °C and the upper one is 38 °C. The duty floor is 30 % of full scale and the ceiling is 100 %.

Top module: `fan_curve_top`

## Requirements
- R1: After reset `dutyLevel` is 256 and `fanPwm` is continuously high. Both stay so until the first valid sample has been committed.
- R2: A sample at or below 30 °C (for example 20 or 30) yields duty 76, which is floor(30 × 256 / 100).
- R3: A sample strictly between 30 and 38 °C yields duty 76 + floor((T − 30) × 180 / 8). This gives 98 at 31 °C, 166 at 34 °C and 233 at 37 °C, and the committed duty always lies between 76 and 256 inclusive.
- R4: A sample at or above 38 °C (for example 38 or 200) yields duty 256, and `fanPwm` is then high in every cycle.
- R5: Each PWM period is 256 cycles, and the counter starts at zero after reset. In each period `fanPwm` is high during exactly the first `dutyLevel` cycles and low for the rest.
- R6: `dutyLevel` changes only at the boundary after the last cycle of a period. A sample accepted before that last cycle is committed at that boundary. A sample presented in the last cycle itself is committed one period later.
- R7: `sampleTemp` has no effect while `sampleValid` is low. When several samples arrive before one boundary, only the last one is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Qualifies `sampleTemp` for one cycle |
| sampleTemp | input | 8 | Temperature sample, unsigned whole degrees Celsius |
| fanPwm | output | 1 | PWM fan drive, registered |
| dutyLevel | output | 9 | Active duty in counts out of 256 |

## Verification
The hardest case to reach from the ports is a sample that lands exactly in the last cycle of a PWM period. The design must hold it back for a full period rather than commit the stale pending level. The bench's behavioural model keeps its own period counter. The stimulus waits until that counter shows the final count, raises the strobe in that cycle, and then checks the old duty one cycle later and the new duty one period later. Samples that arrive in bursts within one period, and temperature changes with the strobe low, are driven the same way against the model.

// File: rtl/fan_curve_pkg.sv
package fan_curve_pkg;

  typedef struct packed {
    logic loadTarget;
    logic commitDuty;
  } fanStrobe_t;

endpackage

// File: rtl/fan_curve_map.sv
module fan_curve_map #(
  parameter int TEMP_W  = 8,
  parameter int DUTY_W  = 9,
  parameter int LO_SET  = 30,
  parameter int HI_SET  = 38,
  parameter int DUTY_LO = 76,
  parameter int DUTY_HI = 256
) (
  input  logic [TEMP_W-1:0] tempIn,
  output logic [DUTY_W-1:0] dutyCalc
);

  localparam int SPAN   = HI_SET - LO_SET;
  localparam int RISE   = DUTY_HI - DUTY_LO;
  localparam int PROD_W = TEMP_W + DUTY_W + 1;

  logic [PROD_W-1:0] offset;
  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] quotient;

  always_comb begin
    offset   = PROD_W'(tempIn) - PROD_W'(LO_SET);
    product  = offset * PROD_W'(RISE);
    quotient = product / PROD_W'(SPAN);
    if (tempIn <= TEMP_W'(LO_SET)) begin
      dutyCalc = DUTY_W'(DUTY_LO);
    end else if (tempIn >= TEMP_W'(HI_SET)) begin
      dutyCalc = DUTY_W'(DUTY_HI);
    end else begin
      dutyCalc = DUTY_W'(DUTY_LO) + DUTY_W'(quotient);
    end
  end

endmodule

// File: rtl/fan_curve_ctrl.sv
module fan_curve_ctrl
  import fan_curve_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sampleValid,
  input  logic       periodEnd,
  output fanStrobe_t strobe
);

  logic pending;

  always_comb begin
    strobe.loadTarget = sampleValid;
    strobe.commitDuty = periodEnd && pending && !sampleValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
    end else if (sampleValid) begin
      pending <= 1'b1;
    end else if (strobe.commitDuty) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/fan_curve_dp.sv
module fan_curve_dp
  import fan_curve_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int CNT_W   = 8,
  parameter int LO_SET  = 30,
  parameter int HI_SET  = 38,
  parameter int DUTY_LO = 76,
  parameter int DUTY_HI = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  fanStrobe_t        strobe,
  input  logic [TEMP_W-1:0] tempIn,
  output logic              periodEnd,
  output logic              pwmOut,
  output logic [CNT_W:0]    dutyOut
);

  localparam int DUTY_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0]  pwmCnt;
  logic [CNT_W-1:0]  cntNext;
  logic [DUTY_W-1:0] targetDuty;
  logic [DUTY_W-1:0] activeDuty;
  logic [DUTY_W-1:0] activeNext;
  logic [DUTY_W-1:0] dutyCalc;
  logic              pwmQ;

  fan_curve_map #(
    .TEMP_W (TEMP_W),
    .DUTY_W (DUTY_W),
    .LO_SET (LO_SET),
    .HI_SET (HI_SET),
    .DUTY_LO(DUTY_LO),
    .DUTY_HI(DUTY_HI)
  ) u_map (
    .tempIn  (tempIn),
    .dutyCalc(dutyCalc)
  );

  always_comb begin
    periodEnd  = (pwmCnt == CNT_LAST);
    cntNext    = pwmCnt + 1'b1;
    activeNext = strobe.commitDuty ? targetDuty : activeDuty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwmCnt     <= '0;
      targetDuty <= DUTY_W'(DUTY_HI);
      activeDuty <= DUTY_W'(DUTY_HI);
      pwmQ       <= 1'b1;
    end else begin
      pwmCnt     <= cntNext;
      activeDuty <= activeNext;
      pwmQ       <= ({1'b0, cntNext} < activeNext);
      if (strobe.loadTarget) begin
        targetDuty <= dutyCalc;
      end
    end
  end

  assign pwmOut  = pwmQ;
  assign dutyOut = activeDuty;

  assert_hold_mid_period_R6 : assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> $stable(activeDuty));

  assert_duty_bounds_R3 : assert property (@(posedge clk) disable iff (rst)
    (activeDuty >= DUTY_W'(DUTY_LO)) && (activeDuty <= DUTY_W'(DUTY_HI)));

  assert_full_duty_high_R4 : assert property (@(posedge clk) disable iff (rst)
    (activeDuty == DUTY_W'(DUTY_HI)) && (DUTY_HI == (1 << CNT_W)) |-> pwmQ);

  assert_low_clamp_R2 : assert property (@(posedge clk) disable iff (rst)
    strobe.loadTarget && (tempIn <= TEMP_W'(LO_SET)) |=> targetDuty == DUTY_W'(DUTY_LO));

  assert_high_clamp_R4 : assert property (@(posedge clk) disable iff (rst)
    strobe.loadTarget && (tempIn >= TEMP_W'(HI_SET)) |=> targetDuty == DUTY_W'(DUTY_HI));

endmodule

// File: rtl/fan_curve_top.sv
module fan_curve_top
  import fan_curve_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int CNT_W    = 8,
  parameter int LO_SET   = 30,
  parameter int HI_SET   = 38,
  parameter int FLOOR_PC = 30,
  parameter int CEIL_PC  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  output logic              fanPwm,
  output logic [CNT_W:0]    dutyLevel
);

  localparam int FULL    = 1 << CNT_W;
  localparam int DUTY_LO = FLOOR_PC * FULL / 100;
  localparam int DUTY_HI = CEIL_PC * FULL / 100;

  fanStrobe_t strobe;
  logic       periodEnd;

  fan_curve_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .periodEnd  (periodEnd),
    .strobe     (strobe)
  );

  fan_curve_dp #(
    .TEMP_W (TEMP_W),
    .CNT_W  (CNT_W),
    .LO_SET (LO_SET),
    .HI_SET (HI_SET),
    .DUTY_LO(DUTY_LO),
    .DUTY_HI(DUTY_HI)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .tempIn   (sampleTemp),
    .periodEnd(periodEnd),
    .pwmOut   (fanPwm),
    .dutyOut  (dutyLevel)
  );

endmodule

// File: tb/fan_curve_top_tb.sv
module fan_curve_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sampleValid = 1'b0;
  logic [7:0] sampleTemp = 8'd0;
  logic       fanPwm;
  logic [8:0] dutyLevel;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int mCnt = 0;
  int mActive = 256;
  int mTarget = 256;
  bit mPending = 0;

  always #4 clk = ~clk;

  fan_curve_top u_dut (
    .clk        (clk),
    .rst        (rst),
    .sampleValid(sampleValid),
    .sampleTemp (sampleTemp),
    .fanPwm     (fanPwm),
    .dutyLevel  (dutyLevel)
  );

  function automatic int curve(int t);
    if (t <= 30) return 76;
    if (t >= 38) return 256;
    return 76 + ((t - 30) * 180) / 8;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mActive = 256; mTarget = 256; mPending = 0;
    end else begin
      bit commit;
      int oldTarget;
      commit = (mCnt == 255) && mPending && !sampleValid;
      oldTarget = mTarget;
      if (sampleValid) begin
        mTarget = curve(int'(sampleTemp));
        mPending = 1;
      end
      if (commit) begin
        mActive = oldTarget;
        mPending = 0;
      end
      mCnt = (mCnt + 1) % 256;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(int'(dutyLevel) == mActive, "R6 duty vs model", int'(dutyLevel), mActive);
      check(fanPwm == (mCnt < mActive), "R5 pwm vs model", int'(fanPwm), int'(mCnt < mActive));
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendSample(int t);
    @(negedge clk);
    sampleTemp = 8'(t);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic settle(int t, int exp, string tag);
    sendSample(t);
    waitCyc(300);
    check(int'(dutyLevel) == exp, tag, int'(dutyLevel), exp);
  endtask

  task automatic countHigh(int exp, string tag);
    int highs = 0;
    while (mCnt != 0) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      if (fanPwm) highs++;
      @(negedge clk);
    end
    check(highs == exp, tag, highs, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    waitCyc(4);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset default is full duty
    check(int'(dutyLevel) == 256, "R1 reset duty", int'(dutyLevel), 256);
    check(fanPwm == 1'b1, "R1 reset pwm", int'(fanPwm), 1);
    countHigh(256, "R1 full before first sample");
    // R2
    settle(20, 76, "R2 cold 20C");
    settle(30, 76, "R2 at lower set point");
    // R3
    settle(31, 98, "R3 31C");
    settle(34, 166, "R3 34C");
    settle(37, 233, "R3 37C");
    // R4
    settle(38, 256, "R4 upper set point");
    settle(200, 256, "R4 hot 200C");
    countHigh(256, "R4 always high");
    // R5
    settle(30, 76, "R5 setup");
    countHigh(76, "R5 high count at floor");
    settle(34, 166, "R5 setup mid");
    countHigh(166, "R5 high count mid");
    // R6: sample in the last cycle of a period
    settle(30, 76, "R6 setup");
    while (mCnt != 255) @(negedge clk);
    sampleTemp = 8'd34;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check(int'(dutyLevel) == 76, "R6 last-cycle sample held", int'(dutyLevel), 76);
    waitCyc(250);
    check(int'(dutyLevel) == 76, "R6 still held mid period", int'(dutyLevel), 76);
    waitCyc(10);
    check(int'(dutyLevel) == 166, "R6 committed next boundary", int'(dutyLevel), 166);
    // R7: no strobe, no effect
    sampleTemp = 8'd38;
    waitCyc(600);
    check(int'(dutyLevel) == 166, "R7 temp ignored without valid", int'(dutyLevel), 166);
    // R7: last of several samples wins
    while (mCnt != 10) @(negedge clk);
    sendSample(31);
    sendSample(37);
    waitCyc(300);
    check(int'(dutyLevel) == 233, "R7 last sample wins", int'(dutyLevel), 233);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule